// File: doc/BRIEF.md
# Multi-Cycle Restoring Unsigned Divider

This block divides one unsigned N-bit operand by another over a fixed number of clock cycles, using subtract-and-restore iterations. A double-width divisor register is loaded with the divisor sitting in its upper half. A double-width partial-remainder register is loaded with the dividend, zero-extended. On every iteration the block trial-subtracts the divisor from the partial remainder. A negative trial leaves the remainder as it was and shifts a 0 into the quotient. A zero or positive trial keeps the difference and shifts a 1 into the quotient. The divisor register then moves one place to the right.

A client presents both operands with a one-cycle `start` while the block is idle. `busy` stays high for N+1 cycles. `done` then pulses for a single cycle, and `quotient` and `remainder` hold their values until the next accepted start. A zero divisor raises no flag. It produces an all-ones quotient and returns the dividend as the remainder. The asynchronous reset input is released synchronously inside the block, so the block needs two clock edges after the reset release before it accepts a start.

Top module: `restoring_divider`

## Requirements
- R1: After reset, `busy` and `done` are low and `quotient` and `remainder` read zero.
- R2: A `start` sampled high while `busy` is low captures `dividend` and `divisor` at that edge, and `busy` reads high from the next cycle.
- R3: `busy` stays high for exactly N+1 cycles. `done` is high for exactly one cycle, the cycle right after the last iteration, and `busy` is low in that cycle.
- R4: For a nonzero divisor, when `done` is high, `quotient` equals floor(dividend/divisor) and `remainder` equals dividend mod divisor. As a worked case for N=4, 7 divided by 2 gives 3 remainder 1.
- R5: For a zero divisor, when `done` is high, `quotient` is all ones (2^N-1) and `remainder` equals the dividend.
- R6: A `start` sampled while `busy` is high is ignored: the running operation finishes with the operands captured at its own start.
- R7: After `done`, `quotient` and `remainder` keep their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division; accepted only when `busy` is low |
| dividend | input | N | Unsigned numerator, sampled with an accepted `start` |
| divisor | input | N | Unsigned denominator, sampled with an accepted `start` |
| busy | output | 1 | High while iterations are in progress |
| done | output | 1 | One-cycle pulse when the results become valid |
| quotient | output | N | Unsigned quotient |
| remainder | output | N | Unsigned remainder |

## Verification
Each quotient bit is decided only once, so a wrong comparison or a missed restore stays in the result. It shows up as a quotient or remainder mismatch in the `done` cycle of that same operation, N+1 cycles after the start. A fault in the iteration counter shows up at the ports right away as `done` arriving early or late, or `busy` lasting the wrong number of cycles. A fault in the load or hold logic shows up as results that come from the wrong operands, or as outputs that drift during the idle cycles after `done`. The exhaustive sweep over a 4-bit instance reaches every operand pair, including every zero-divisor case.

// File: rtl/restoring_divider_pkg.sv
package restoring_divider_pkg;
  typedef enum logic {
    DV_IDLE = 1'b0,
    DV_RUN  = 1'b1
  } dv_state_e;
endpackage

// File: rtl/dv_rst_sync.sv
module dv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/dv_ctrl.sv
module dv_ctrl #(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);
  import restoring_divider_pkg::*;

  localparam int ITERS = N + 1;
  localparam int CW    = $clog2(ITERS + 1);
  localparam logic [CW-1:0] LAST = CW'(ITERS - 1);

  dv_state_e      state_q, state_n;
  logic [CW-1:0]  cnt_q, cnt_n;
  logic           done_q, done_n;
  logic           cnt_en;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    done_n  = 1'b0;
    load    = 1'b0;
    step    = 1'b0;
    cnt_en  = 1'b0;
    unique case (state_q)
      DV_IDLE: begin
        if (start) begin
          load    = 1'b1;
          state_n = DV_RUN;
          cnt_n   = '0;
          cnt_en  = 1'b1;
        end
      end
      DV_RUN: begin
        step   = 1'b1;
        cnt_en = 1'b1;
        cnt_n  = cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          state_n = DV_IDLE;
          done_n  = 1'b1;
        end
      end
      default: state_n = DV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DV_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      done_q  <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_n;
    end
  end

  assign busy = (state_q == DV_RUN);
  assign done = done_q;
endmodule

// File: rtl/dv_datapath.sv
module dv_datapath #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [N-1:0] dividend,
  input  logic [N-1:0] divisor,
  output logic [N-1:0] quotient,
  output logic [N-1:0] remainder
);
  localparam int W = 2 * N;

  logic [W-1:0] dsr_q, dsr_n;
  logic [W-1:0] prem_q, prem_n;
  logic [N-1:0] quo_q, quo_n;
  logic [W:0]   trial;
  logic         trial_neg;
  logic         reg_en;

  assign trial     = {1'b0, prem_q} - {1'b0, dsr_q};
  assign trial_neg = trial[W];
  assign reg_en    = load | step;

  always_comb begin
    dsr_n  = dsr_q;
    prem_n = prem_q;
    quo_n  = quo_q;
    if (load) begin
      dsr_n  = {divisor, {N{1'b0}}};
      prem_n = {{N{1'b0}}, dividend};
      quo_n  = '0;
    end else if (step) begin
      if (!trial_neg) begin
        prem_n = trial[W-1:0];
      end
      quo_n = {quo_q[N-2:0], ~trial_neg};
      dsr_n = {1'b0, dsr_q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dsr_q  <= '0;
      prem_q <= '0;
      quo_q  <= '0;
    end else if (reg_en) begin
      dsr_q  <= dsr_n;
      prem_q <= prem_n;
      quo_q  <= quo_n;
    end
  end

  assign quotient  = quo_q;
  assign remainder = prem_q[N-1:0];
endmodule

// File: rtl/restoring_divider.sv
module restoring_divider #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] dividend,
  input  logic [N-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [N-1:0] quotient,
  output logic [N-1:0] remainder
);
  logic rst_i_n;
  logic load;
  logic step;

  dv_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  dv_ctrl #(.N(N)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_i_n),
    .start (start),
    .load  (load),
    .step  (step),
    .busy  (busy),
    .done  (done)
  );

  dv_datapath #(.N(N)) u_dp (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .load      (load),
    .step      (step),
    .dividend  (dividend),
    .divisor   (divisor),
    .quotient  (quotient),
    .remainder (remainder)
  );
endmodule

// File: rtl/restoring_divider_chk.sv
module restoring_divider_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [N-1:0] dividend,
  input logic [N-1:0] divisor,
  input logic         busy,
  input logic         done,
  input logic [N-1:0] quotient,
  input logic [N-1:0] remainder
);
  localparam int CW = $clog2(N + 3);

  logic [N-1:0]  cap_dvd;
  logic [N-1:0]  cap_dvs;
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_dvd <= '0;
      cap_dvs <= '0;
      run_cnt <= '0;
    end else if (start && !busy) begin
      cap_dvd <= dividend;
      cap_dvs <= divisor;
      run_cnt <= '0;
    end else if (busy) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R3
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_cnt == CW'(N + 1))); // R3
  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !done) |=> busy); // R2
  AST_QUOT_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_dvs != '0) |-> (quotient == cap_dvd / cap_dvs)); // R4
  AST_REM_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_dvs != '0) |-> (remainder == cap_dvd % cap_dvs)); // R4
  AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_dvs == '0) |-> (quotient == '1 && remainder == cap_dvd)); // R5
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !(run_cnt == CW'(N))) |=> busy); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start && !done) |=> ($stable(quotient) && $stable(remainder))); // R7
endmodule

bind restoring_divider restoring_divider_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .dividend  (dividend),
  .divisor   (divisor),
  .busy      (busy),
  .done      (done),
  .quotient  (quotient),
  .remainder (remainder)
);

// File: tb/sim_restoring_divider.sv
`timescale 1ns/1ps
module sim_restoring_divider;
  localparam int N = 4;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic [N-1:0] dividend;
  logic [N-1:0] divisor;
  logic         busy;
  logic         done;
  logic [N-1:0] quotient;
  logic [N-1:0] remainder;

  int vectors;
  int miscompares;
  int cycles;

  restoring_divider #(.N(N)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dividend  (dividend),
    .divisor   (divisor),
    .busy      (busy),
    .done      (done),
    .quotient  (quotient),
    .remainder (remainder)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      miscompares = miscompares + 1;
      $display("FAIL watchdog: actual run still going, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp_v);
    vectors = vectors + 1;
    if (act != exp_v) begin
      miscompares = miscompares + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  // One operation: start at a negedge, follow each cycle, check results.
  // When poke is set, a second start with other operands is driven mid-run.
  task automatic run_one(input int a, input int b, input bit poke);
    int exp_q;
    int exp_r;
    int held_q;
    int held_r;
    exp_q = (b == 0) ? (1 << N) - 1 : a / b;
    exp_r = (b == 0) ? a : a % b;
    @(negedge clk);
    start    = 1'b1;
    dividend = N'(a);
    divisor  = N'(b);
    @(negedge clk);
    start    = 1'b0;
    dividend = N'(~a);
    divisor  = N'(b + 1);
    if (busy !== 1'b1) check("R2 busy after start", int'(busy), 1);
    for (int i = 1; i <= N + 1; i++) begin
      if (poke && i == 2) start = 1'b1;
      if (poke && i == 3) start = 1'b0;
      @(negedge clk);
      if (i <= N) begin
        if (done !== 1'b0 || busy !== 1'b1) begin
          check("R3 busy window", int'({busy, done}), 2);
        end
      end
    end
    start = 1'b0;
    check("R3 done pulse", int'({busy, done}), 1);
    if (b == 0) begin
      check("R5 quotient zero divisor", int'(quotient), exp_q);
      check("R5 remainder zero divisor", int'(remainder), exp_r);
    end else if (poke) begin
      check("R6 quotient after ignored start", int'(quotient), exp_q);
      check("R6 remainder after ignored start", int'(remainder), exp_r);
    end else begin
      check("R4 quotient", int'(quotient), exp_q);
      check("R4 remainder", int'(remainder), exp_r);
    end
    held_q = int'(quotient);
    held_r = int'(remainder);
    @(negedge clk);
    check("R3 done drops", int'(done), 0);
    @(negedge clk);
    check("R7 quotient held", int'(quotient), held_q);
    check("R7 remainder held", int'(remainder), held_r);
  endtask

  initial begin
    vectors     = 0;
    miscompares = 0;
    cycles      = 0;
    rst_n       = 1'b0;
    start       = 1'b0;
    dividend    = '0;
    divisor     = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 busy at reset", int'(busy), 0);
    check("R1 done at reset", int'(done), 0);
    check("R1 quotient at reset", int'(quotient), 0);
    check("R1 remainder at reset", int'(remainder), 0);

    run_one(7, 2, 1'b0);  // R4 worked case: 3 remainder 1
    for (int a = 0; a < (1 << N); a++) begin
      for (int b = 0; b < (1 << N); b++) begin
        run_one(a, b, 1'b0);
      end
    end
    run_one(15, 4, 1'b1);
    run_one(9, 0, 1'b1);
    run_one(13, 13, 1'b1);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule